// File: doc/BRIEF.md
# Link Control and Status Register with Retrain Tracking

This block holds the 32-bit control and status word of a serial link port and the logic around it. Host software reads the word and writes it through a simple bus port. A separate management write path can update two fields that software can only read. On the link side, the block watches the current state code of the training state machine and three event pulses. The first pulse marks the end of training. The second marks a speed or width change made to repair an unreliable link. The third marks an autonomous speed or width change made for any other reason.

The block drives three outputs. A single-cycle retrain request and a level disable request go to the training state machine. A level interrupt is asserted while an enabled bandwidth status flag is set. A retrain command that software issues while the link is not in its active state is held pending. It is released in the first cycle the link is active. While it waits, it shows in the training-status bit. The negotiated speed and width come in as input values and are registered for reads.

Top module: `link_ctl_stat`

## Requirements
- R1: During reset, and after it until the first update, the word reads 0x0041_0000: speed code 1 in bits 19:16 and width 4 in bits 25:20. The retrain_req, disable_req and irq outputs are 0.
- R2: Bits 1:0, 4, 6, 7, 9, 10 and 11 store the value of a software write. Software writes to bits 3 and 28 have no effect. Bits 2, 15:12, 26 and 29 always read 0.
- R3: Bit 5 always reads 0. If software writes 1 to it while trn_state is 3 (active), retrain_req is high for exactly one cycle, in the cycle after the write.
- R4: If the 1 is written to bit 5 while trn_state is not 3, the request is held. retrain_req rises in the first cycle that trn_state equals 3, lasts one cycle, and the hold is dropped in that cycle.
- R5: Bit 27 reads 1 when trn_state is 4 (recovery) or 2 (configuration), or while a retrain request is held. Otherwise it reads 0.
- R6: disable_req is high exactly while bit 4 holds 1.
- R7: Bit 30 is set one cycle after ev_fix_change. It is also set one cycle after ev_train_done, but only if a retrain_req has been issued since the last ev_train_done. An ev_train_done with no retrain before it leaves bit 30 unchanged.
- R8: Bit 31 is set one cycle after ev_auto_change.
- R9: A software write with 1 in bit 30 or bit 31 clears that bit. A write with 0 in that bit leaves it unchanged. If a set event arrives in the same cycle as the clearing write, the bit is set.
- R10: irq is high while (bit 30 and bit 10) or (bit 31 and bit 11) are both set.
- R11: A management write whose address has bit 21 set loads bit 3 (0 = 64-byte, 1 = 128-byte completion boundary) and bit 28 (slot clock) from its data. A management write without address bit 21 set has no effect.
- R12: Bits 19:16 and 25:20 show neg_speed and neg_width one cycle after those inputs change.
- R13: With parameter BW_NOTIFY = 0, bits 10, 11, 30 and 31 read 0 and irq stays low whatever is written or signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register word |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_addr | input | MGMT_AW | Management write address; bit MGMT_SEL enables the write |
| mgmt_wdata | input | 32 | Management write data |
| trn_state | input | ST_W | Training state code (3 active, 4 recovery, 2 configuration) |
| ev_train_done | input | 1 | Pulse: link training finished |
| ev_fix_change | input | 1 | Pulse: speed or width changed to repair the link |
| ev_auto_change | input | 1 | Pulse: autonomous speed or width change |
| neg_speed | input | 4 | Negotiated speed code |
| neg_width | input | 6 | Negotiated width |
| retrain_req | output | 1 | One-cycle retrain request |
| disable_req | output | 1 | Level request to hold the link disabled |
| irq | output | 1 | Level bandwidth interrupt |

## Verification
The hardest case to reach from the ports is a retrain command that must wait. The command has to be written while the state code is neither active nor a training state, so that bit 27 shows only the pending request. The state is then held in recovery for several cycles without any pulse, and moved to active on a falling edge so that the one-cycle pulse can be seen in that very cycle. After that, an ev_train_done has to be placed so that it is credited to the retrain, and a second ev_train_done sent with no retrain before it must leave bit 30 alone. The set-against-clear race is forced by driving ev_fix_change and a clearing write on the same edge.

// File: rtl/link_ctl_stat.sv
module link_ctl_stat #(
  parameter int BW_NOTIFY = 1,
  parameter int MGMT_AW   = 22,
  parameter int MGMT_SEL  = 21,
  parameter int ST_W      = 4,
  parameter int ST_ACT    = 3,
  parameter int ST_RCV    = 4,
  parameter int ST_CFG    = 2,
  parameter int SPD_RST   = 1,
  parameter int WID_RST   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_wr,
  input  logic [31:0]        sw_wdata,
  output logic [31:0]        sw_rdata,
  input  logic               mgmt_wr,
  input  logic [MGMT_AW-1:0] mgmt_addr,
  input  logic [31:0]        mgmt_wdata,
  input  logic [ST_W-1:0]    trn_state,
  input  logic               ev_train_done,
  input  logic               ev_fix_change,
  input  logic               ev_auto_change,
  input  logic [3:0]         neg_speed,
  input  logic [5:0]         neg_width,
  output logic               retrain_req,
  output logic               disable_req,
  output logic               irq
);

  localparam logic BW_EN = (BW_NOTIFY != 0);

  logic [1:0] pm_ctl;
  logic       cmp_bnd, lnk_off, com_clk, ext_sync, aw_dis;
  logic       bm_ie, ab_ie, slot_clk;
  logic [3:0] spd_q;
  logic [5:0] wid_q;
  logic       pend_q, rtr_live_q, bm_st, ab_st;

  wire in_act   = (trn_state == ST_W'(ST_ACT));
  wire in_train = (trn_state == ST_W'(ST_RCV)) || (trn_state == ST_W'(ST_CFG));
  wire mgmt_hit = mgmt_wr && mgmt_addr[MGMT_SEL];
  wire bm_set   = BW_EN && (ev_fix_change || (ev_train_done && rtr_live_q));
  wire ab_set   = BW_EN && ev_auto_change;

  assign retrain_req = pend_q && in_act;
  assign disable_req = lnk_off;
  assign irq         = (bm_st && bm_ie) || (ab_st && ab_ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_ctl   <= 2'b00;
      lnk_off  <= 1'b0;
      com_clk  <= 1'b0;
      ext_sync <= 1'b0;
      aw_dis   <= 1'b0;
      bm_ie    <= 1'b0;
      ab_ie    <= 1'b0;
    end else if (sw_wr) begin
      pm_ctl   <= sw_wdata[1:0];
      lnk_off  <= sw_wdata[4];
      com_clk  <= sw_wdata[6];
      ext_sync <= sw_wdata[7];
      aw_dis   <= sw_wdata[9];
      bm_ie    <= BW_EN && sw_wdata[10];
      ab_ie    <= BW_EN && sw_wdata[11];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_bnd  <= 1'b0;
      slot_clk <= 1'b0;
    end else if (mgmt_hit) begin
      cmp_bnd  <= mgmt_wdata[3];
      slot_clk <= mgmt_wdata[28];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd_q <= 4'(SPD_RST);
      wid_q <= 6'(WID_RST);
    end else begin
      spd_q <= neg_speed;
      wid_q <= neg_width;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      rtr_live_q <= 1'b0;
    end else begin
      if (sw_wr && sw_wdata[5]) pend_q <= 1'b1;
      else if (retrain_req)     pend_q <= 1'b0;
      if (retrain_req)          rtr_live_q <= 1'b1;
      else if (ev_train_done)   rtr_live_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bm_st <= 1'b0;
      ab_st <= 1'b0;
    end else begin
      if (bm_set)                     bm_st <= 1'b1;
      else if (sw_wr && sw_wdata[30]) bm_st <= 1'b0;
      if (ab_set)                     ab_st <= 1'b1;
      else if (sw_wr && sw_wdata[31]) ab_st <= 1'b0;
    end
  end

  always_comb begin
    sw_rdata        = '0;
    sw_rdata[1:0]   = pm_ctl;
    sw_rdata[3]     = cmp_bnd;
    sw_rdata[4]     = lnk_off;
    sw_rdata[6]     = com_clk;
    sw_rdata[7]     = ext_sync;
    sw_rdata[9]     = aw_dis;
    sw_rdata[10]    = bm_ie;
    sw_rdata[11]    = ab_ie;
    sw_rdata[19:16] = spd_q;
    sw_rdata[25:20] = wid_q;
    sw_rdata[27]    = in_train || pend_q;
    sw_rdata[28]    = slot_clk;
    sw_rdata[30]    = bm_st;
    sw_rdata[31]    = ab_st;
  end

  // R3
  retrain_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |-> trn_state == ST_W'(ST_ACT));

  // R4
  retrain_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_req && !(sw_wr && sw_wdata[5])) |=> !retrain_req);

  // R6
  disable_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> disable_req == $past(sw_wdata[4]));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata[31] && !ev_auto_change) |=> !sw_rdata[31]);

  // R10
  auto_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_auto_change && ab_ie && !(sw_wr && !sw_wdata[11])) |=> irq);

  // R3
  retrain_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rdata[5]);

endmodule

// File: tb/link_ctl_stat_tb_top.sv
module link_ctl_stat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        mgmt_wr = 1'b0;
  logic [21:0] mgmt_addr = '0;
  logic [31:0] mgmt_wdata = '0;
  logic [3:0]  trn_state = 4'd1;
  logic        ev_train_done = 1'b0, ev_fix_change = 1'b0, ev_auto_change = 1'b0;
  logic [3:0]  neg_speed = 4'd2;
  logic [5:0]  neg_width = 6'd8;
  logic [31:0] rdata, rdata_nb;
  logic        retrain_req, disable_req, irq;
  logic        retrain_nb, disable_nb, irq_nb;
  int          errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  link_ctl_stat dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(rdata),
    .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .trn_state(trn_state), .ev_train_done(ev_train_done), .ev_fix_change(ev_fix_change),
    .ev_auto_change(ev_auto_change), .neg_speed(neg_speed), .neg_width(neg_width),
    .retrain_req(retrain_req), .disable_req(disable_req), .irq(irq));

  link_ctl_stat #(.BW_NOTIFY(0)) dut_nb (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(rdata_nb),
    .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .trn_state(trn_state), .ev_train_done(ev_train_done), .ev_fix_change(ev_fix_change),
    .ev_auto_change(ev_auto_change), .neg_speed(neg_speed), .neg_width(neg_width),
    .retrain_req(retrain_nb), .disable_req(disable_nb), .irq(irq_nb));

  localparam logic [31:0] RW_MASK = 32'h0000_0ED3;
  localparam logic [31:0] LIVE    = 32'h0082_0000;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0ED3, 32'h1000_F00C, 32'h0000_0241, 32'h2400_0482,
    32'h0000_0810, 32'h0000_0000 };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk); sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk); sw_wr = 1'b0; sw_wdata = '0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ev_train_done = 1'b1;
    if (which == 1) ev_fix_change = 1'b1;
    if (which == 2) ev_auto_change = 1'b1;
    @(negedge clk);
    ev_train_done = 1'b0; ev_fix_change = 1'b0; ev_auto_change = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", rdata, 32'h0041_0000);
    check("R1 reset outputs", {29'd0, retrain_req, disable_req, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    check("R12 speed/width follow inputs", rdata, LIVE);

    // R2: table of writes with expected readback
    for (int i = 0; i < NV; i++) begin
      sw_write(VEC[i]);
      check("R2 rw fields", rdata, (VEC[i] & RW_MASK) | LIVE);
    end

    // R6
    sw_write(32'h0000_0010);
    check("R6 disable on", {31'd0, disable_req}, 32'd1);
    sw_write(32'h0);
    check("R6 disable off", {31'd0, disable_req}, 32'd0);

    // R4 / R5: pending retrain outside active state
    trn_state = 4'd1;
    sw_write(32'h0000_0020);
    check("R3 bit5 reads 0", {31'd0, rdata[5]}, 32'd0);
    check("R5 pending shows in bit27", {31'd0, rdata[27]}, 32'd1);
    check("R4 no pulse while not active", {31'd0, retrain_req}, 32'd0);
    trn_state = 4'd4;
    repeat (3) @(negedge clk);
    check("R4 no pulse in recovery", {31'd0, retrain_req}, 32'd0);
    trn_state = 4'd3;
    #1;
    check("R4 pulse on entering active", {31'd0, retrain_req}, 32'd1);
    @(negedge clk);
    check("R4 pulse lasts one cycle", {31'd0, retrain_req}, 32'd0);
    check("R5 bit27 clear after release", {31'd0, rdata[27]}, 32'd0);

    // R7: training finished after retrain
    pulse(0);
    check("R7 set after retrain done", {31'd0, rdata[30]}, 32'd1);
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    sw_write(32'h0000_0400);
    check("R10 irq with enable", {31'd0, irq}, 32'd1);
    sw_write(32'h4000_0400);
    check("R9 write-one clears bit30", {31'd0, rdata[30]}, 32'd0);
    check("R10 irq drops", {31'd0, irq}, 32'd0);
    pulse(0);
    check("R7 done without retrain ignored", {31'd0, rdata[30]}, 32'd0);

    // R3: retrain written while active
    sw_write(32'h0000_0020);
    check("R3 pulse after write in active", {31'd0, retrain_req}, 32'd1);
    @(negedge clk);
    check("R3 single cycle", {31'd0, retrain_req}, 32'd0);

    // R5: training states
    trn_state = 4'd2; #1;
    check("R5 configuration", {31'd0, rdata[27]}, 32'd1);
    trn_state = 4'd4; #1;
    check("R5 recovery", {31'd0, rdata[27]}, 32'd1);
    trn_state = 4'd3; #1;
    check("R5 active idle", {31'd0, rdata[27]}, 32'd0);

    // R7 fix change, R9 set wins
    pulse(1);
    check("R7 fix change sets", {31'd0, rdata[30]}, 32'd1);
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = 32'h4000_0000; ev_fix_change = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0; sw_wdata = '0; ev_fix_change = 1'b0;
    check("R9 set wins over clear", {31'd0, rdata[30]}, 32'd1);
    sw_write(32'h4000_0000);
    check("R9 bit30 cleared", {31'd0, rdata[30]}, 32'd0);

    // R8 / R10 autonomous change
    sw_write(32'h0000_0800);
    pulse(2);
    check("R8 auto change sets", {31'd0, rdata[31]}, 32'd1);
    check("R10 irq from bit31", {31'd0, irq}, 32'd1);
    sw_write(32'h0000_0800);
    check("R9 write 0 keeps bit31", {31'd0, rdata[31]}, 32'd1);
    sw_write(32'h8000_0000);
    check("R9 bit31 cleared", {31'd0, rdata[31]}, 32'd0);

    // R13 capability off
    sw_write(32'h0000_0C00);
    pulse(1);
    pulse(2);
    check("R13 fields forced 0", rdata_nb & 32'hC000_0C00, 32'd0);
    check("R13 irq low", {31'd0, irq_nb}, 32'd0);
    sw_write(32'hC000_0000);

    // R11 management path
    @(negedge clk);
    mgmt_wr = 1'b1; mgmt_addr = 22'h0; mgmt_wdata = 32'h1000_0008;
    @(negedge clk); mgmt_wr = 1'b0;
    check("R11 no select bit ignored", rdata & 32'h1000_0008, 32'd0);
    mgmt_wr = 1'b1; mgmt_addr = 22'h20_0000;
    @(negedge clk); mgmt_wr = 1'b0;
    check("R11 select bit writes", rdata & 32'h1000_0008, 32'h1000_0008);
    sw_write(32'h0);
    check("R2 sw cannot touch 3 and 28", rdata & 32'h1000_0008, 32'h1000_0008);

    // R12 input change
    neg_speed = 4'd4; neg_width = 6'd16;
    @(negedge clk);
    check("R12 new speed/width", rdata & 32'h03FF_0000, 32'h0104_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule